// File: doc/BRIEF.md
# Per-Ply Capture-Order Move Enumerator

This block walks through the pseudo-legal moves of one search ply in most-valuable-victim, least-valuable-aggressor order. It does not find attacks. A separate priority selector does that. The enumerator asks the selector for a target square, then for attacker squares against that target, and hands each resulting from/to pair to the search engine. The only state it keeps is a 64-bit disable mask per ply. Bit n of every mask stands for square n. A set bit hides that square from the selector, so each new request yields a square that has not been offered before.

The masks sit in a stack, one per ply. The engine pushes a new ply while a move is made, and pops it once the child ply reports that it has run dry. The parent then resumes exactly where it stopped. It waits for the unmake of its outstanding move before moving on to the next attacker. Pushing past the configured depth raises a sticky overflow flag and leaves the stack unchanged.

Top module: `movegen_seq`

## Requirements
- R1: After reset, depth_o is 0, stack_ovf is 0, and sel_req, mv_valid and gen_done are all low.
- R2: A ply_push while the block is idle, or while it waits for an unmake, opens a new ply whose disable mask is all zero. The next cycle then shows a victim request (sel_mode 0) with sel_mask 0, and depth_o is one higher.
- R3: A victim request presents the ply's current mask on sel_mask. An acknowledged victim request with sel_found 0 ends the ply: gen_done is high from the next cycle until a pop.
- R4: An acknowledged victim request with sel_found 1 records sel_square as the victim and clears every own_pieces bit in the mask. The next cycle shows an aggressor request (sel_mode 1) carrying that victim on sel_victim and the new mask.
- R5: An acknowledged aggressor request with sel_found 1 raises mv_valid in the next cycle, with mv_from set to the aggressor square and mv_to set to the victim. Both stay stable until mv_ready is seen high.
- R6: Once a move is accepted, the block waits for unmake_done. The unmake sets the move's from bit in the mask and issues a new aggressor request against the same victim.
- R7: An acknowledged aggressor request with sel_found 0 sets the victim's bit in the mask and returns to a victim request.
- R8: A ply_pop while gen_done is high drops one ply. At depth 1 the block goes back to idle. Deeper, the parent's mask, victim and from-square return unchanged and the block waits for the parent's unmake_done.
- R9: A ply_push while waiting at depth DEPTH sets stack_ovf, which stays set until reset. depth_o does not change.
- R10: ply_push is ignored while a request, a move or an exhausted ply is pending. ply_pop is ignored except when gen_done is high. While waiting, ply_push takes priority over a simultaneous unmake_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ply_push | input | 1 | Open a child ply |
| ply_pop | input | 1 | Close the exhausted ply |
| own_pieces | input | 64 | Squares holding the mover's pieces |
| sel_req | output | 1 | Request to the priority selector |
| sel_mode | output | 1 | 0 = find victim, 1 = find aggressor |
| sel_mask | output | 64 | Disable mask for the request |
| sel_victim | output | 6 | Target square for an aggressor search |
| sel_ack | input | 1 | Selector response valid this cycle |
| sel_found | input | 1 | Selector found a square |
| sel_square | input | 6 | Square returned by the selector |
| mv_valid | output | 1 | Move offered to the search engine |
| mv_ready | input | 1 | Search engine takes the move |
| mv_from | output | 6 | Origin square of the move |
| mv_to | output | 6 | Target square of the move |
| unmake_done | input | 1 | Pulse: the offered move has been unmade |
| gen_done | output | 1 | Current ply has no moves left |
| depth_o | output | 6 | Number of open plies |
| stack_ovf | output | 1 | Sticky push-overflow flag |

## Verification
Every input is sampled on a rising edge, and its effect appears on the outputs just after that same edge:
- a selector response produces the next request, a move or gen_done one cycle later;
- a push, pop or unmake changes depth_o and sel_mask one cycle later.

The bench keeps a per-ply mask array, a victim and from-square per ply, and a state variable. It steps these on the rising edge from the same inputs the design sees. It compares every output on the falling edge that follows, so each expected value falls in the one cycle the requirements assign to it. The selector, the engine's stalls and stray push/pop pulses are all produced by the bench, and the model reacts to them in the same cycle.

// File: rtl/movegen_pkg.sv
package movegen_pkg;
    localparam int N_SQ = 64;
    localparam int SQ_W = $clog2(N_SQ);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_VIC  = 3'd1,
        ST_AGG  = 3'd2,
        ST_EMIT = 3'd3,
        ST_WAIT = 3'd4,
        ST_DONE = 3'd5
    } seq_state_e;

    // Everything one ply needs to resume: mask, current victim, outstanding origin.
    typedef struct packed {
        logic [N_SQ-1:0] mask;
        logic [SQ_W-1:0] victim;
        logic [SQ_W-1:0] from;
    } ply_frame_t;

    function automatic logic [N_SQ-1:0] sq_bit(input logic [SQ_W-1:0] sq);
        logic [N_SQ-1:0] b;
        b = '0;
        b[sq] = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/ply_frame_stack.sv
module ply_frame_stack
    import movegen_pkg::*;
#(
    parameter int ENTRIES = 31,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ply_frame_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output ply_frame_t       rd_data
);
    ply_frame_t mem_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                mem_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (int'(rd_idx) == i)
                rd_data = mem_q[i];
    end
endmodule

// File: rtl/movegen_seq.sv
module movegen_seq
    import movegen_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int DW = $clog2(DEPTH + 1),
    localparam int ENTRIES = DEPTH - 1,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ply_push,
    input  logic             ply_pop,
    input  logic [N_SQ-1:0]  own_pieces,
    output logic             sel_req,
    output logic             sel_mode,
    output logic [N_SQ-1:0]  sel_mask,
    output logic [SQ_W-1:0]  sel_victim,
    input  logic             sel_ack,
    input  logic             sel_found,
    input  logic [SQ_W-1:0]  sel_square,
    output logic             mv_valid,
    input  logic             mv_ready,
    output logic [SQ_W-1:0]  mv_from,
    output logic [SQ_W-1:0]  mv_to,
    input  logic             unmake_done,
    output logic             gen_done,
    output logic [DW-1:0]    depth_o,
    output logic             stack_ovf
);
    typedef struct packed {
        seq_state_e  st;
        logic [DW-1:0] depth;
        ply_frame_t  cur;
        logic        ovf;
    } seq_reg_t;

    seq_reg_t   q, d;
    logic       stk_wr;
    ply_frame_t stk_rd;
    logic [DW-1:0] dep_m1, dep_m2;

    assign dep_m1 = q.depth - DW'(1);
    assign dep_m2 = q.depth - DW'(2);

    // Parents of the live ply only; the live frame stays in registers.
    ply_frame_stack #(.ENTRIES(ENTRIES)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (stk_wr),
        .wr_idx (dep_m1[IDX_W-1:0]),
        .wr_data(q.cur),
        .rd_idx (dep_m2[IDX_W-1:0]),
        .rd_data(stk_rd)
    );

    always_comb begin
        d      = q;
        stk_wr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ply_push) begin
                    d.depth = DW'(1);
                    d.cur   = '0;
                    d.st    = ST_VIC;
                end
            end
            ST_VIC: begin
                if (sel_ack) begin
                    if (!sel_found) begin
                        d.st = ST_DONE;
                    end else begin
                        d.cur.victim = sel_square;
                        d.cur.mask   = q.cur.mask & ~own_pieces;
                        d.st         = ST_AGG;
                    end
                end
            end
            ST_AGG: begin
                if (sel_ack) begin
                    if (!sel_found) begin
                        d.cur.mask = q.cur.mask | sq_bit(q.cur.victim);
                        d.st       = ST_VIC;
                    end else begin
                        d.cur.from = sel_square;
                        d.st       = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (mv_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (ply_push) begin
                    if (q.depth == DW'(DEPTH)) begin
                        d.ovf = 1'b1;
                    end else begin
                        stk_wr  = 1'b1;
                        d.depth = q.depth + DW'(1);
                        d.cur   = '0;
                        d.st    = ST_VIC;
                    end
                end else if (unmake_done) begin
                    d.cur.mask = q.cur.mask | sq_bit(q.cur.from);
                    d.st       = ST_AGG;
                end
            end
            ST_DONE: begin
                if (ply_pop) begin
                    d.depth = dep_m1;
                    if (q.depth == DW'(1)) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.cur = stk_rd;
                        d.st  = ST_WAIT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel_req    = (q.st == ST_VIC) || (q.st == ST_AGG);
    assign sel_mode   = (q.st == ST_AGG);
    assign sel_mask   = q.cur.mask;
    assign sel_victim = q.cur.victim;
    assign mv_valid   = (q.st == ST_EMIT);
    assign mv_from    = q.cur.from;
    assign mv_to      = q.cur.victim;
    assign gen_done   = (q.st == ST_DONE);
    assign depth_o    = q.depth;
    assign stack_ovf  = q.ovf;
endmodule

// File: rtl/movegen_seq_chk.sv
module movegen_seq_chk
    import movegen_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ply_push,
    input logic            sel_req,
    input logic            sel_mode,
    input logic [N_SQ-1:0] sel_mask,
    input logic [SQ_W-1:0] sel_victim,
    input logic            sel_ack,
    input logic            sel_found,
    input logic [SQ_W-1:0] sel_square,
    input logic            mv_valid,
    input logic            mv_ready,
    input logic [SQ_W-1:0] mv_from,
    input logic [SQ_W-1:0] mv_to,
    input logic            gen_done,
    input logic [DW-1:0]   depth_o,
    input logic            stack_ovf
);
    logic idle_like;
    assign idle_like = !sel_req && !mv_valid && !gen_done;

    // R1
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_req, mv_valid, gen_done}));

    // R2
    open_ply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ply_push && idle_like && depth_o == '0) |=>
        (sel_req && !sel_mode && sel_mask == '0 && depth_o == DW'(1)));

    // R3
    vic_exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && !sel_mode && sel_ack && !sel_found) |=> gen_done);

    // R5
    move_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && sel_mode && sel_ack && sel_found) |=>
        (mv_valid && mv_from == $past(sel_square) && mv_to == $past(sel_victim)));

    // R5
    move_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_from) && $stable(mv_to)));

    // R7
    victim_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && sel_mode && sel_ack && !sel_found) |=>
        (sel_req && !sel_mode && sel_mask[$past(sel_victim)]));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ply_push && idle_like && depth_o == DW'(DEPTH)) |=> (stack_ovf && $stable(depth_o)));
endmodule

bind movegen_seq movegen_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ply_push  (ply_push),
    .sel_req   (sel_req),
    .sel_mode  (sel_mode),
    .sel_mask  (sel_mask),
    .sel_victim(sel_victim),
    .sel_ack   (sel_ack),
    .sel_found (sel_found),
    .sel_square(sel_square),
    .mv_valid  (mv_valid),
    .mv_ready  (mv_ready),
    .mv_from   (mv_from),
    .mv_to     (mv_to),
    .gen_done  (gen_done),
    .depth_o   (depth_o),
    .stack_ovf (stack_ovf)
);

// File: tb/movegen_seq_tb.sv
module movegen_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int DW = $clog2(DEPTH + 1);
    localparam int MAX_CYC = 150000;

    localparam int M_IDLE = 0, M_VIC = 1, M_AGG = 2, M_EMIT = 3, M_WAIT = 4, M_DONE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ply_push = 1'b0, ply_pop = 1'b0, mv_ready = 1'b0, unmake_done = 1'b0, ack_en = 1'b0;
    logic [63:0] own_r = '0, vict_r = '0;
    logic sel_req, sel_mode, sel_ack, sel_found, mv_valid, gen_done, stack_ovf;
    logic [63:0] sel_mask;
    logic [5:0] sel_victim, sel_square, mv_from, mv_to;
    logic [DW-1:0] depth_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    movegen_seq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ply_push(ply_push), .ply_pop(ply_pop),
        .own_pieces(own_r), .sel_req(sel_req), .sel_mode(sel_mode),
        .sel_mask(sel_mask), .sel_victim(sel_victim), .sel_ack(sel_ack),
        .sel_found(sel_found), .sel_square(sel_square), .mv_valid(mv_valid),
        .mv_ready(mv_ready), .mv_from(mv_from), .mv_to(mv_to),
        .unmake_done(unmake_done), .gen_done(gen_done), .depth_o(depth_o),
        .stack_ovf(stack_ovf)
    );

    // Bench selector: lowest eligible target (victims) or own square (aggressors).
    function automatic void pick(input logic mode, input logic [63:0] mask,
                                 output bit f, output int sq);
        logic [63:0] t;
        t = (mode ? own_r : vict_r) & ~mask;
        f = 0; sq = 0;
        for (int i = 63; i >= 0; i--) if (t[i]) begin f = 1; sq = i; end
    endfunction

    bit b_f; int b_sq;
    always_comb begin
        pick(sel_mode, sel_mask, b_f, b_sq);
    end
    assign sel_ack    = sel_req & ack_en;
    assign sel_found  = b_f;
    assign sel_square = b_sq[5:0];

    // Reference model
    int ms, md;
    logic [63:0] mw [0:DEPTH+1];
    int mvic [0:DEPTH+1];
    int mfrom [0:DEPTH+1];
    bit movf;
    string mtag;

    always @(posedge clk) begin
        bit f; int sq;
        if (!rst_n) begin
            ms = M_IDLE; md = 0; movf = 0; mtag = "R1";
        end else begin
            case (ms)
                M_IDLE: if (ply_push) begin
                    md = 1; mw[1] = '0; mvic[1] = 0; mfrom[1] = 0; ms = M_VIC; mtag = "R2";
                end
                M_VIC: if (ack_en) begin
                    pick(1'b0, mw[md], f, sq);
                    if (!f) begin ms = M_DONE; mtag = "R3"; end
                    else begin mvic[md] = sq; mw[md] = mw[md] & ~own_r; ms = M_AGG; mtag = "R4"; end
                end
                M_AGG: if (ack_en) begin
                    pick(1'b1, mw[md], f, sq);
                    if (!f) begin mw[md][mvic[md]] = 1'b1; ms = M_VIC; mtag = "R7"; end
                    else begin mfrom[md] = sq; ms = M_EMIT; mtag = "R5"; end
                end
                M_EMIT: if (mv_ready) begin ms = M_WAIT; mtag = "R5"; end
                M_WAIT: begin
                    if (ply_push) begin
                        if (md == DEPTH) begin movf = 1; mtag = "R9"; end
                        else begin
                            md++; mw[md] = '0; mvic[md] = 0; mfrom[md] = 0; ms = M_VIC;
                            mtag = unmake_done ? "R10" : "R2";
                        end
                    end else if (unmake_done) begin
                        mw[md][mfrom[md]] = 1'b1; ms = M_AGG; mtag = "R6";
                    end
                end
                M_DONE: if (ply_pop) begin
                    md--; ms = (md == 0) ? M_IDLE : M_WAIT; mtag = "R8";
                end
                default: ms = M_IDLE;
            endcase
        end
    end

    int nvec = 0, nfail = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string t;
        t = mtag;
        chk(t, "sel_req",  64'(sel_req),  64'(ms == M_VIC || ms == M_AGG));
        chk(t, "sel_mode", 64'(sel_mode && sel_req), 64'(ms == M_AGG));
        chk(t, "mv_valid", 64'(mv_valid), 64'(ms == M_EMIT));
        chk(t, "gen_done", 64'(gen_done), 64'(ms == M_DONE));
        chk(t, "depth_o",  64'(depth_o),  64'(md));
        chk((movf ? "R9" : t), "stack_ovf", 64'(stack_ovf), 64'(movf));
        if (ms == M_VIC || ms == M_AGG) chk(t, "sel_mask", sel_mask, mw[md]);
        if (ms == M_AGG) chk("R4", "sel_victim", 64'(sel_victim), 64'(mvic[md]));
        if (ms == M_EMIT) begin
            chk("R5", "mv_from", 64'(mv_from), 64'(mfrom[md]));
            chk("R5", "mv_to",   64'(mv_to),   64'(mvic[md]));
        end
    endtask

    int cyc = 0;
    bit hung = 0;
    int unsigned rnd = 32'h1ace_b00c;
    bit tried [0:DEPTH+1];

    task automatic step_rnd();
        rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
    endtask

    // Plays the search engine: chain of first-move pushes up to maxd plies.
    task automatic run_phase(input logic [63:0] v, input logic [63:0] o, input int maxd);
        bit started;
        vict_r = v; own_r = o; started = 0;
        while (!hung) begin
            @(negedge clk);
            cyc++;
            if (cyc > MAX_CYC) begin
                hung = 1; nfail++;
                $display("FAIL watchdog R1 act=%0d exp<%0d", cyc, MAX_CYC);
                break;
            end
            compare_all();
            if (started && ms == M_IDLE) break;
            step_rnd();
            ply_push = 0; ply_pop = 0; unmake_done = 0;
            ack_en   = (rnd % 4) != 0;
            mv_ready = ((rnd >> 4) % 3) != 0;
            case (ms)
                M_IDLE: begin ply_push = 1; started = 1; tried[1] = 0; end
                M_WAIT: begin
                    if (!tried[md] && md < maxd) begin
                        ply_push = 1; tried[md] = 1; tried[md+1] = 0;
                        unmake_done = (rnd >> 8) % 2; // R10 push wins over unmake
                    end else begin
                        unmake_done = ((rnd >> 9) % 4) != 0; // R6
                    end
                    ply_pop = (rnd >> 12) % 5 == 0; // R10 stray pop ignored
                end
                M_DONE: begin
                    ply_pop = ((rnd >> 10) % 3) != 0; // R8
                    ply_push = (rnd >> 14) % 4 == 0; // R10 stray push ignored
                end
                default: begin
                    ply_push = (rnd >> 16) % 6 == 0; // R10
                    ply_pop  = (rnd >> 19) % 6 == 0; // R10
                end
            endcase
        end
        ply_push = 0; ply_pop = 0; unmake_done = 0;
    endtask

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "depth_o",  64'(depth_o), 64'd0);
        chk("R1", "stack_ovf", 64'(stack_ovf), 64'd0);
        chk("R1", "outputs idle", 64'({sel_req, mv_valid, gen_done}), 64'd0);
        rst_n = 1;
        // R3: no victims at all, ply ends at once
        run_phase(64'h0, 64'h0000_0000_0002_0201, 1);
        // R4 R5 R6 R7 R8: three victims (incl. square 63), three aggressors (incl. square 0)
        run_phase((64'd1 << 63) | (64'd1 << 50) | (64'd1 << 40),
                  (64'd1 << 17) | (64'd1 << 9) | 64'd1, 3);
        // R2 R8: victim on square 0, aggressor on square 63
        run_phase(64'd1, 64'd1 << 63, 2);
        // R9: chain deeper than the stack
        run_phase(64'd1 << 20, (64'd1 << 2) | (64'd1 << 1), DEPTH + 1);
        chk("R9", "stack_ovf final", 64'(stack_ovf), 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule